// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital control part of an eight-bit successive approximation analog-to-digital converter. It puts a trial code on an external DAC and reads back one comparator bit that says whether the DAC sum is larger than the analog input. It then settles the code one bit per clock, from the most significant bit down to the least significant bit. The DAC, comparator, reference and input network are outside the block.

A single convert input controls it. While convert is high, the sequencer is held in its cleared state and the ready flag is high. When convert falls, a conversion starts. Eight clocks later the ready flag goes low to show that the result is valid. The result stays in place until convert rises again. A separate active-low enable input puts the result on a three-state data bus. When the enable is off, the bus is left undriven so that other sources can share it.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters its idle state: `rdy_o` = 1, `dac_code_o` = 0, and the data bus is undriven while `den_n_i` = 1.
- R2: After `conv_i` rises, `rdy_o` is 1 and `dac_code_o` is 0 by the third rising clock edge. Both stay that way for as long as `conv_i` stays high, whatever the comparator reports.
- R3: A conversion starts only on the fall of `conv_i`. `dac_code_o` stays 0 across the first two edges after the fall and shows 8'h80 (bit 7 on trial) after the third edge. A rise of `conv_i` never starts a trial.
- R4: Bits are tried one per clock in the order 7, 6, …, 0. After the k-th edge that follows the start (k = 1..7), bit 7-k of `dac_code_o` is 1 and every bit below it is 0.
- R5: At each trial edge, `cmp_over_i` = 1 (DAC sum above the input) clears the bit under test, and `cmp_over_i` = 0 keeps it set. Bits already decided do not change.
- R6: `rdy_o` stays 1 through the first seven trial edges and goes to 0 on the eighth edge after the start. With an ideal comparator the final code equals the input value, for all 256 values.
- R7: Once `rdy_o` is 0, the result and `rdy_o` hold steady until `conv_i` rises again. Comparator activity has no effect on them.
- R8: A rise of `conv_i` during a conversion aborts it. `rdy_o` returns to 1 and `dac_code_o` returns to 0, and the next fall starts a fresh conversion.
- R9: While `den_n_i` = 0, `data_io` carries the code register. While `den_n_i` = 1, every bit of `data_io` is undriven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock, one bit decision per period |
| rst_n | input | 1 | Synchronous reset, active low |
| conv_i | input | 1 | Convert pulse, asynchronous; high holds the clear state, the fall starts a conversion |
| cmp_over_i | input | 1 | Comparator result: 1 when the DAC sum exceeds the input |
| den_n_i | input | 1 | Data enable, active low |
| dac_code_o | output | 8 | Trial code driven to the DAC |
| rdy_o | output | 1 | Ready flag: 1 while cleared or converting, 0 when the result is valid |
| data_io | inout | 8 | Three-state result bus |

## Verification
The assertions assume that `conv_i` stays at each level for at least three clocks, so that each level crosses the two-stage synchronizer and the fall can be seen as an edge. They also assume that `cmp_over_i` is settled at each trial edge as a function of the code currently shown. The bench changes `conv_i` and `den_n_i` a quarter period after a rising edge and holds every convert level for several clocks. Its comparator model is a combinational compare of `dac_code_o` against the stimulus, or a constant in the stuck modes, so the comparator never changes near a sampling edge. The bench drives the shared bus only while `den_n_i` is high, and it drives the inverse of the expected result so that any drive from the block would be seen.

// File: rtl/sar_conv_pkg.sv
// Package: shared types of the successive approximation sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package sar_conv_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // after reset, no result yet
        ST_HOLD = 2'd1,   // convert high, logic held cleared
        ST_CONV = 2'd2,   // one bit trial per clock
        ST_DONE = 2'd3    // result valid, held
    } sar_state_e;

endpackage

// File: rtl/sar_conv_sync.sv
// Module: sar_conv_sync
// Brings the asynchronous convert pulse into the clock domain through a
// chain of flip-flops and reports its synchronized level and falling edge.
// Assumes: STAGES >= 2; the pulse holds each level for at least STAGES+1 clocks.
module sar_conv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // first stage captures the raw input
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_i;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // each later stage resamples the one before it
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    // remembers the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = last_q & ~chain_q[STAGES-1];

    AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> $past(level_o)); // R3

endmodule

// File: rtl/sar_conv_fsm.sv
// Module: sar_conv_fsm
// Phase controller: holds the clear state while convert is high, starts the
// trials on the convert fall, steps the bit index down once per clock and
// flags completion after the last bit.
// Assumes: level_i and fall_i come from the synchronizer; fall_i is a one-clock pulse.
module sar_conv_fsm
    import sar_conv_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            level_i,
    input  logic            fall_i,
    output logic            clear_o,
    output logic            start_o,
    output logic            step_o,
    output logic [IDXW-1:0] idx_o,
    output logic            rdy_o
);

    localparam logic [IDXW-1:0] TOP_IDX = IDXW'(WIDTH - 1);

    sar_state_e      state_q, state_d;
    logic [IDXW-1:0] idx_q, idx_d;

    // next phase: convert level dominates, then start, then trial progress
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_IDLE;
            ST_HOLD: state_d = ST_HOLD;
            ST_CONV: state_d = (idx_q == '0) ? ST_DONE : ST_CONV;
            ST_DONE: state_d = ST_DONE;
            default: state_d = ST_IDLE;
        endcase
        if (fall_i)  state_d = ST_CONV;
        if (level_i) state_d = ST_HOLD;
    end

    // next bit index: reload on start, count down during trials
    always_comb begin
        idx_d = idx_q;
        if (level_i)                               idx_d = TOP_IDX;
        else if (fall_i)                           idx_d = TOP_IDX;
        else if (state_q == ST_CONV && idx_q != '0) idx_d = idx_q - 1'b1;
    end

    // phase and index registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= TOP_IDX;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    assign clear_o = level_i;
    assign start_o = fall_i & ~level_i;
    assign step_o  = (state_q == ST_CONV) & ~level_i;
    assign idx_o   = idx_q;
    assign rdy_o   = (state_q != ST_DONE);

    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        level_i |=> (state_q == ST_HOLD)); // R2
    AST_START_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && !level_i) |=> (state_q == ST_CONV && idx_q == TOP_IDX)); // R3
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && !level_i && !fall_i && idx_q != '0) |=> (idx_q == $past(idx_q) - 1'b1)); // R4
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_o) |-> $past(state_q == ST_CONV && idx_q == '0)); // R6
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !level_i) |=> (state_q == ST_DONE)); // R7
    AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && level_i) |=> rdy_o); // R8

endmodule

// File: rtl/sar_conv_reg.sv
// Module: sar_conv_reg
// The successive approximation register: clears, loads the top trial bit,
// and on each step keeps or drops the bit under test and sets the next one.
// Assumes: at most one of start/step is active unless clear overrides both.
module sar_conv_reg #(
    parameter int WIDTH = 8,
    localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             start_i,
    input  logic             step_i,
    input  logic [IDXW-1:0]  idx_i,
    input  logic             cmp_over_i,
    output logic [WIDTH-1:0] code_o
);

    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] code_q, code_d, trial_d;

    // decision for the bit under test plus arming of the next lower bit
    always_comb begin
        trial_d = code_q;
        for (int b = 0; b < WIDTH; b++) begin
            if (IDXW'(b) == idx_i)                    trial_d[b] = ~cmp_over_i;
            if (b + 1 < WIDTH && IDXW'(b + 1) == idx_i) trial_d[b] = 1'b1;
        end
    end

    // priority: clear, then start, then step, else hold
    always_comb begin
        if (clear_i)      code_d = '0;
        else if (start_i) code_d = TOP_BIT;
        else if (step_i)  code_d = trial_d;
        else              code_d = code_q;
    end

    // code register
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    assign code_o = code_q;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (code_q == '0)); // R2
    AST_DROP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && cmp_over_i) |=> !code_q[$past(idx_i)]); // R5
    AST_KEEP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && !cmp_over_i) |=> code_q[$past(idx_i)]); // R5
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !start_i && !step_i) |=> $stable(code_q)); // R7

endmodule

// File: rtl/sar_conv_ctrl.sv
// Module: sar_conv_ctrl (top)
// Sequencer for a successive approximation converter: synchronizes the
// convert pulse, runs one bit trial per clock, drives the trial code to the
// DAC and offers the result on a three-state bus under an active-low enable.
// Assumes: comparator output is valid at each edge for the code shown.
module sar_conv_ctrl #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_i,
    input  logic             cmp_over_i,
    input  logic             den_n_i,
    output logic [WIDTH-1:0] dac_code_o,
    output logic             rdy_o,
    inout  wire  [WIDTH-1:0] data_io
);

    logic            conv_lvl, conv_fall;
    logic            clr, start, step;
    logic [IDXW-1:0] idx;
    logic [WIDTH-1:0] code;

    sar_conv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (conv_i),
        .level_o (conv_lvl),
        .fall_o  (conv_fall)
    );

    sar_conv_fsm #(.WIDTH(WIDTH)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (conv_lvl),
        .fall_i  (conv_fall),
        .clear_o (clr),
        .start_o (start),
        .step_o  (step),
        .idx_o   (idx),
        .rdy_o   (rdy_o)
    );

    sar_conv_reg #(.WIDTH(WIDTH)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clr),
        .start_i    (start),
        .step_i     (step),
        .idx_i      (idx),
        .cmp_over_i (cmp_over_i),
        .code_o     (code)
    );

    assign dac_code_o = code;

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bus
            // per-bit three-state driver on the result bus
            assign data_io[g] = den_n_i ? 1'bz : code[g];
        end
    endgenerate

    AST_HELD_DAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        conv_lvl |=> (dac_code_o == '0 && rdy_o)); // R2
    AST_RESULT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_o && !conv_lvl) |=> (!rdy_o && $stable(dac_code_o))); // R7

endmodule

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb;

    localparam int CLK_PERIOD = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv = 1'b0;
    logic       den_n = 1'b1;
    logic [7:0] dac;
    logic       rdy;
    wire  [7:0] bus;
    logic       tb_drv = 1'b0;
    logic [7:0] tb_val = 8'h00;
    logic [7:0] vin = 8'h00;
    logic [1:0] mode = 2'd0;   // 0 ideal, 1 always over, 2 never over
    logic       cmp;
    int         checks = 0;
    int         fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cmp = (mode == 2'd1) ? 1'b1 : (mode == 2'd2) ? 1'b0 : (dac > vin);
    assign bus = tb_drv ? tb_val : 8'hzz;

    sar_conv_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_i     (conv),
        .cmp_over_i (cmp),
        .den_n_i    (den_n),
        .dac_code_o (dac),
        .rdy_o      (rdy),
        .data_io    (bus)
    );

    // {mode, input, expected result}
    localparam int NVEC = 12;
    localparam logic [17:0] VECS [NVEC] = '{
        {2'd0, 8'h00, 8'h00}, {2'd0, 8'hFF, 8'hFF}, {2'd0, 8'h80, 8'h80},
        {2'd0, 8'h7F, 8'h7F}, {2'd0, 8'h01, 8'h01}, {2'd0, 8'hFE, 8'hFE},
        {2'd0, 8'hA5, 8'hA5}, {2'd0, 8'h5A, 8'h5A}, {2'd1, 8'h40, 8'h00},
        {2'd2, 8'h40, 8'hFF}, {2'd0, 8'h3C, 8'h3C}, {2'd0, 8'hC3, 8'hC3}
    };

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // expected upper decided bits after k trial edges
    function automatic logic [7:0] decided(input logic [1:0] m, input logic [7:0] v, input int k);
        logic [7:0] mask;
        mask = 8'hFF << (8 - k);
        if (m == 2'd1)      return 8'h00;
        else if (m == 2'd2) return mask;
        else                return v & mask;
    endfunction

    task automatic bus_checks(input logic [7:0] exp, input string req);
        den_n = 1'b0;
        #1;
        check(bus === exp, req, bus, exp);
        den_n = 1'b1;
        tb_val = ~exp;
        tb_drv = 1'b1;
        #1;
        check(bus === ~exp, "R9 hi-z", bus, ~exp);
        tb_drv = 1'b0;
    endtask

    task automatic run_conv(input logic [1:0] m, input logic [7:0] v, input logic [7:0] exp, input bit walk);
        mode = m;
        vin = v;
        conv = 1'b1;
        tick(); tick(); tick();
        check(rdy === 1'b1, "R2 ready high", {7'd0, rdy}, 8'd1);
        check(dac === 8'h00, "R2 cleared", dac, 8'h00);
        tick(); tick();
        check(dac === 8'h00, "R3 no start on rise", dac, 8'h00);
        conv = 1'b0;
        tick(); tick();
        check(dac === 8'h00, "R3 not started yet", dac, 8'h00);
        tick();
        check(dac === 8'h80, "R3 start code", dac, 8'h80);
        for (int k = 1; k < 8; k++) begin
            tick();
            if (walk) begin
                check(dac === (decided(m, v, k) | (8'h80 >> k)), "R4 R5 trial code", dac,
                      decided(m, v, k) | (8'h80 >> k));
                check(rdy === 1'b1, "R6 still busy", {7'd0, rdy}, 8'd1);
            end
        end
        tick();
        check(rdy === 1'b0, "R6 done", {7'd0, rdy}, 8'd0);
        bus_checks(exp, "R6 R9 result");
    endtask

    initial begin
        // R1: reset state
        tick(); tick();
        check(rdy === 1'b1, "R1 ready", {7'd0, rdy}, 8'd1);
        check(dac === 8'h00, "R1 code", dac, 8'h00);
        tb_val = 8'h3E; tb_drv = 1'b1; #1;
        check(bus === 8'h3E, "R1 bus undriven", bus, 8'h3E);
        tb_drv = 1'b0;
        rst_n = 1'b1;
        tick();

        // table walk with per-trial checks
        for (int i = 0; i < NVEC; i++)
            run_conv(VECS[i][17:16], VECS[i][15:8], VECS[i][7:0], 1'b1);

        // R6: every input value with the ideal comparator
        for (int v = 0; v < 256; v++)
            run_conv(2'd0, 8'(v), 8'(v), 1'b0);

        // R7: result holds against comparator activity
        run_conv(2'd0, 8'h96, 8'h96, 1'b0);
        mode = 2'd1; tick(); tick();
        mode = 2'd2; vin = 8'h00; tick(); tick();
        check(rdy === 1'b0, "R7 ready held", {7'd0, rdy}, 8'd0);
        bus_checks(8'h96, "R7 result held");

        // R2: long convert-high phase ignores the comparator
        mode = 2'd2; conv = 1'b1;
        tick(); tick(); tick();
        for (int k = 0; k < 6; k++) begin
            tick();
            check(dac === 8'h00 && rdy === 1'b1, "R2 held in clear", dac, 8'h00);
        end
        conv = 1'b0; mode = 2'd0; vin = 8'h11;
        for (int k = 0; k < 11; k++) tick();
        check(rdy === 1'b0, "R2 completes after release", {7'd0, rdy}, 8'd0);
        bus_checks(8'h11, "R2 result after release");

        // R8: abort during conversion
        mode = 2'd0; vin = 8'hE7; conv = 1'b1;
        tick(); tick(); tick(); tick();
        conv = 1'b0;
        tick(); tick(); tick(); tick(); tick(); tick();
        conv = 1'b1;
        tick(); tick(); tick();
        check(dac === 8'h00, "R8 abort clears code", dac, 8'h00);
        check(rdy === 1'b1, "R8 abort ready", {7'd0, rdy}, 8'd1);
        run_conv(2'd0, 8'h2B, 8'h2B, 1'b1);

        // R1: reset in the middle of a conversion
        vin = 8'h77; conv = 1'b1;
        tick(); tick(); tick();
        conv = 1'b0;
        tick(); tick(); tick(); tick(); tick();
        rst_n = 1'b0;
        tick();
        check(rdy === 1'b1, "R1 mid reset ready", {7'd0, rdy}, 8'd1);
        check(dac === 8'h00, "R1 mid reset code", dac, 8'h00);
        rst_n = 1'b1;
        tick();
        run_conv(2'd0, 8'h77, 8'h77, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule